// File: doc/BRIEF.md
# Banked Code and Data Address Decoder

This block sits between an 8-bit microcontroller core and its memories. The core presents one bus cycle at a time: a 16-bit address together with a code-fetch strobe, a data-read strobe or a data-write strobe. The block turns that cycle into exactly one target select. The targets are an 18-bit address into a 256 KB external program ROM, the on-chip general RAM page, the scratch RAM page, the external data RAM, the scratch code memory, or the window of memory-mapped control registers. All decoding is combinational, so a select and a ROM address are valid in the same cycle as the strobe.

The block owns two registers. The first is a ROM bank register, which places the 32 KB code window onto one of eight 32 KB blocks of the ROM. The second is a configuration register whose remap bit moves the scratch RAM out of data space and into the bottom 256 bytes of code space. Code addresses in the upper half of the 64 KB space fold back onto the lower half. Data reads in the upper half return program ROM from the current bank. Data writes to the upper half are dropped. The external-access input decides whether scratch code memory is allowed at all. When it is low, every fetch goes to the external ROM.

Top module: `mcu_memmap_decoder`

## Requirements
- R1: After reset the bank register is 000b and the remap bit is 0, so a fetch of 1234h selects ROM address 01234h, and reads of 7FF3h and 7FF4h both return 00h.
- R2: A code fetch that selects the ROM drives rom_addr = {bank[2:0], addr[14:0]}, so fetches of X and X+8000h reach the same ROM location.
- R3: The bank register sits at data address 7FF3h. A write loads wdata[2:0], and fetches in the next cycle use the new bank. A read returns the bank in bits 2:0 with bits 7:3 at 0.
- R4: The configuration register sits at data address 7FF4h, and its remap bit is bit 3. A write loads wdata[3], and a read returns only that bit, with every other bit at 0.
- R5: While ext_access is low, every code fetch selects the external ROM and never the scratch code memory.
- R6: While ext_access is high and the remap bit is 1, a fetch whose addr[14:8] is 0 selects the scratch code memory and not the ROM. This covers 0000h–00FFh and its alias at 8000h–80FFh.
- R7: A data read or write in 7E00h–7EFFh selects the general RAM.
- R8: A data access in 7D00h–7DFFh selects the scratch RAM when the remap bit is 0, and the external data RAM when it is 1.
- R9: A data access in 7F00h–7FFFh selects the control-register window. Any other data access below 8000h, outside the three on-chip pages, selects the external data RAM.
- R10: A data read in 8000h–FFFFh selects the ROM with rom_addr = {bank, addr[14:0]}.
- R11: A data write in 8000h–FFFFh asserts no select and changes no register.
- R12: At most one select is active in any cycle. If a fetch and a data strobe coincide, only the fetch is served and the data access has no effect. If a read and a write coincide, the write is served.
- R13: With no strobe active, no select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the bank and configuration registers |
| ext_access | input | 1 | High permits scratch code memory; low forces every fetch to the external ROM |
| fetch_stb | input | 1 | Code-fetch cycle |
| rd_stb | input | 1 | Data-read cycle |
| wr_stb | input | 1 | Data-write cycle |
| bus_addr | input | 16 | Cycle address |
| wdata | input | 8 | Write data |
| rom_sel | output | 1 | External program ROM selected |
| rom_addr | output | 18 | Banked ROM address |
| scratch_code_sel | output | 1 | Scratch memory selected as code |
| scratch_ram_sel | output | 1 | Scratch memory selected as data |
| gram_sel | output | 1 | On-chip general RAM selected |
| xram_sel | output | 1 | External data RAM selected |
| creg_sel | output | 1 | Control-register window selected |
| creg_rdata | output | 8 | Read data of the bank or configuration register during a read |

## Verification
Two of this block's functions can fall in the same cycle: a code fetch and a data access, or a read and a write. The bench provokes the first by raising the fetch strobe together with a write to the bank register. It then judges that only the ROM select is raised and that a later read of 7FF3h still shows the old bank. It provokes the second by raising the read and write strobes together on 7FF3h. It then checks that the register window is selected, that no read data is driven, and that the bank takes the new value. A full sweep of every address page, across all banks, both remap states and both ext_access levels, compares each select and ROM address against values computed in the bench.

// File: rtl/mm_pkg.sv
package mm_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_FETCH = 2'd1,
      CYC_READ  = 2'd2,
      CYC_WRITE = 2'd3
   } cyc_e;

   typedef struct packed {
      logic rom;
      logic scode;
      logic sram;
      logic gram;
      logic xram;
      logic creg;
   } sel_t;
endpackage

// File: rtl/mm_cycle_arb.sv
module mm_cycle_arb
   import mm_pkg::*;
(
   input  logic fetch_stb,
   input  logic rd_stb,
   input  logic wr_stb,
   output cyc_e cyc
);
   always_comb begin
      if (fetch_stb)   cyc = CYC_FETCH;
      else if (wr_stb) cyc = CYC_WRITE;
      else if (rd_stb) cyc = CYC_READ;
      else             cyc = CYC_IDLE;
   end
endmodule

// File: rtl/mm_regs.sv
module mm_regs
   import mm_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter int          BANK_W    = 3,
   parameter int          MMC_BIT   = 3,
   parameter logic [15:0] BANK_ADDR = 16'h7FF3,
   parameter logic [15:0] CFG_ADDR  = 16'h7FF4,
   parameter int          BANK_RST  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_e              cyc,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [BANK_W-1:0] bank,
   output logic              mmc,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [BANK_W-1:0] BANK_INIT = BANK_W'(BANK_RST);

   logic              hit_bank, hit_cfg;
   logic [DATA_W-1:0] bank_view, cfg_view;
   logic              unused_wdata;

   assign hit_bank     = (addr == ADDR_W'(BANK_ADDR));
   assign hit_cfg      = (addr == ADDR_W'(CFG_ADDR));
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank <= BANK_INIT;
         mmc  <= 1'b0;
      end else if (cyc == CYC_WRITE) begin
         if (hit_bank) bank <= wdata[BANK_W-1:0];
         if (hit_cfg)  mmc  <= wdata[MMC_BIT];
      end
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_view
      if (i < BANK_W) begin : g_bank_bit
         assign bank_view[i] = bank[i];
      end else begin : g_bank_zero
         assign bank_view[i] = 1'b0;
      end
      if (i == MMC_BIT) begin : g_cfg_bit
         assign cfg_view[i] = mmc;
      end else begin : g_cfg_zero
         assign cfg_view[i] = 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (cyc == CYC_READ) begin
         if (hit_bank)     rdata = bank_view;
         else if (hit_cfg) rdata = cfg_view;
      end
   end
endmodule

// File: rtl/mm_code_dec.sv
module mm_code_dec
   import mm_pkg::*;
#(
   parameter int HI_W     = 7,
   parameter bit REMAP_EN = 1'b1
) (
   input  cyc_e            cyc,
   input  logic            ext_access,
   input  logic            mmc,
   input  logic [HI_W-1:0] hi_field,
   output logic            rom,
   output logic            scode
);
   logic scratch_hit;

   if (REMAP_EN) begin : g_remap
      assign scratch_hit = ext_access && mmc && (hi_field == '0);
   end else begin : g_no_remap
      logic unused_remap;
      assign unused_remap = ext_access ^ mmc ^ (^hi_field);
      assign scratch_hit  = 1'b0;
   end

   always_comb begin
      rom   = 1'b0;
      scode = 1'b0;
      if (cyc == CYC_FETCH) begin
         if (scratch_hit) scode = 1'b1;
         else             rom   = 1'b1;
      end
   end
endmodule

// File: rtl/mm_data_dec.sv
module mm_data_dec
   import mm_pkg::*;
#(
   parameter int         PAGE_W  = 8,
   parameter logic [7:0] CREG_PG = 8'h7F,
   parameter logic [7:0] GRAM_PG = 8'h7E,
   parameter logic [7:0] SRAM_PG = 8'h7D
) (
   input  cyc_e              cyc,
   input  logic              mmc,
   input  logic [PAGE_W-1:0] page,
   output sel_t              sel
);
   logic is_data;
   assign is_data = (cyc == CYC_READ) || (cyc == CYC_WRITE);

   always_comb begin
      sel = '0;
      if (is_data) begin
         if (page[PAGE_W-1]) begin
            sel.rom = (cyc == CYC_READ);
         end else if (page == PAGE_W'(CREG_PG)) begin
            sel.creg = 1'b1;
         end else if (page == PAGE_W'(GRAM_PG)) begin
            sel.gram = 1'b1;
         end else if (page == PAGE_W'(SRAM_PG) && !mmc) begin
            sel.sram = 1'b1;
         end else begin
            sel.xram = 1'b1;
         end
      end
   end
endmodule

// File: rtl/mcu_memmap_decoder.sv
module mcu_memmap_decoder
   import mm_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter int          BANK_W    = 3,
   parameter int          MMC_BIT   = 3,
   parameter int          BANK_RST  = 0,
   parameter bit          REMAP_EN  = 1'b1,
   parameter logic [15:0] BANK_ADDR = 16'h7FF3,
   parameter logic [15:0] CFG_ADDR  = 16'h7FF4,
   parameter logic [7:0]  CREG_PG   = 8'h7F,
   parameter logic [7:0]  GRAM_PG   = 8'h7E,
   parameter logic [7:0]  SRAM_PG   = 8'h7D,
   localparam int         WIN_W     = ADDR_W - 1,
   localparam int         ROM_AW    = BANK_W + WIN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_access,
   input  logic              fetch_stb,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              rom_sel,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              scratch_code_sel,
   output logic              scratch_ram_sel,
   output logic              gram_sel,
   output logic              xram_sel,
   output logic              creg_sel,
   output logic [DATA_W-1:0] creg_rdata
);
   localparam int PAGE_W = 8;
   localparam int HI_W   = WIN_W - PAGE_W;

   if (ADDR_W < 10) begin : g_bad_addr
      $error("ADDR_W must be at least 10");
   end
   if (BANK_W < 1 || BANK_W > DATA_W) begin : g_bad_bank
      $error("BANK_W must lie in 1..DATA_W");
   end
   if (MMC_BIT >= DATA_W) begin : g_bad_mmc
      $error("MMC_BIT must index a data bit");
   end
   if (BANK_RST >= (1 << BANK_W)) begin : g_bad_rst
      $error("BANK_RST does not fit in BANK_W bits");
   end

   cyc_e              cyc;
   logic [BANK_W-1:0] bank;
   logic              mmc;
   logic              code_rom, code_scode;
   sel_t              dsel;

   mm_cycle_arb u_arb (
      .fetch_stb (fetch_stb),
      .rd_stb    (rd_stb),
      .wr_stb    (wr_stb),
      .cyc       (cyc)
   );

   mm_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .BANK_W    (BANK_W),
      .MMC_BIT   (MMC_BIT),
      .BANK_ADDR (BANK_ADDR),
      .CFG_ADDR  (CFG_ADDR),
      .BANK_RST  (BANK_RST)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .cyc   (cyc),
      .addr  (bus_addr),
      .wdata (wdata),
      .bank  (bank),
      .mmc   (mmc),
      .rdata (creg_rdata)
   );

   mm_code_dec #(
      .HI_W     (HI_W),
      .REMAP_EN (REMAP_EN)
   ) u_code (
      .cyc        (cyc),
      .ext_access (ext_access),
      .mmc        (mmc),
      .hi_field   (bus_addr[WIN_W-1:PAGE_W]),
      .rom        (code_rom),
      .scode      (code_scode)
   );

   mm_data_dec #(
      .PAGE_W  (PAGE_W),
      .CREG_PG (CREG_PG),
      .GRAM_PG (GRAM_PG),
      .SRAM_PG (SRAM_PG)
   ) u_data (
      .cyc  (cyc),
      .mmc  (mmc),
      .page (bus_addr[ADDR_W-1 -: PAGE_W]),
      .sel  (dsel)
   );

   assign rom_addr         = {bank, bus_addr[WIN_W-1:0]};
   assign rom_sel          = code_rom | dsel.rom;
   assign scratch_code_sel = code_scode;
   assign scratch_ram_sel  = dsel.sram;
   assign gram_sel         = dsel.gram;
   assign xram_sel         = dsel.xram;
   assign creg_sel         = dsel.creg;
   logic unused_dsel;
   assign unused_dsel = dsel.scode;
endmodule

// File: rtl/mm_decoder_checker.sv
module mm_decoder_checker #(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter int          BANK_W    = 3,
   parameter logic [15:0] BANK_ADDR = 16'h7FF3,
   localparam int         WIN_W     = ADDR_W - 1,
   localparam int         ROM_AW    = BANK_W + WIN_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ext_access,
   input logic              fetch_stb,
   input logic              rd_stb,
   input logic              wr_stb,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] wdata,
   input logic              rom_sel,
   input logic [ROM_AW-1:0] rom_addr,
   input logic              scratch_code_sel,
   input logic              scratch_ram_sel,
   input logic              gram_sel,
   input logic              xram_sel,
   input logic              creg_sel
);
   logic [5:0] sels;
   assign sels = {rom_sel, scratch_code_sel, scratch_ram_sel, gram_sel, xram_sel, creg_sel};

   AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sels) <= 1); // R12

   AST_FETCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stb |-> !(scratch_ram_sel || gram_sel || xram_sel || creg_sel)); // R12

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_stb && !rd_stb && !wr_stb) |-> (sels == '0)); // R13

   AST_EA_LOW_ROM: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_stb && !ext_access) |-> (rom_sel && !scratch_code_sel)); // R5

   AST_ALIAS_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !fetch_stb && bus_addr[ADDR_W-1]) |-> (sels == '0)); // R11

   AST_CODE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_stb && rom_sel) |-> (rom_addr[WIN_W-1:0] == bus_addr[WIN_W-1:0])); // R2

   AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !fetch_stb && bus_addr == ADDR_W'(BANK_ADDR))
      |=> (rom_addr[ROM_AW-1:WIN_W] == $past(wdata[BANK_W-1:0]))); // R3
endmodule

bind mcu_memmap_decoder mm_decoder_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .BANK_W    (BANK_W),
   .BANK_ADDR (BANK_ADDR)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .ext_access       (ext_access),
   .fetch_stb        (fetch_stb),
   .rd_stb           (rd_stb),
   .wr_stb           (wr_stb),
   .bus_addr         (bus_addr),
   .wdata            (wdata),
   .rom_sel          (rom_sel),
   .rom_addr         (rom_addr),
   .scratch_code_sel (scratch_code_sel),
   .scratch_ram_sel  (scratch_ram_sel),
   .gram_sel         (gram_sel),
   .xram_sel         (xram_sel),
   .creg_sel         (creg_sel)
);

// File: tb/mcu_memmap_decoder_bench.sv
`timescale 1ns/1ps
module mcu_memmap_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_access = 1'b0;
   logic        fetch_stb = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  wdata = '0;
   logic        rom_sel, scratch_code_sel, scratch_ram_sel, gram_sel, xram_sel, creg_sel;
   logic [17:0] rom_addr;
   logic [7:0]  creg_rdata;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   mcu_memmap_decoder u_mcu_memmap_decoder (
      .clk(clk), .rst_n(rst_n), .ext_access(ext_access),
      .fetch_stb(fetch_stb), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .bus_addr(bus_addr), .wdata(wdata),
      .rom_sel(rom_sel), .rom_addr(rom_addr),
      .scratch_code_sel(scratch_code_sel), .scratch_ram_sel(scratch_ram_sel),
      .gram_sel(gram_sel), .xram_sel(xram_sel), .creg_sel(creg_sel),
      .creg_rdata(creg_rdata)
   );

   // select vector order: rom, scode, sram, gram, xram, creg
   function automatic logic [5:0] model_sel(input int kind, input logic [15:0] a,
                                            input logic m, input logic e);
      logic [7:0] pg;
      pg = a[15:8];
      if (kind == 0) begin
         if (e && m && a[14:8] == 7'd0) return 6'b010000;
         return 6'b100000;
      end
      if (a[15]) return (kind == 1) ? 6'b100000 : 6'b000000;
      if (pg == 8'h7F) return 6'b000001;
      if (pg == 8'h7E) return 6'b000100;
      if (pg == 8'h7D && !m) return 6'b001000;
      return 6'b000010;
   endfunction

   function automatic string model_req(input int kind, input logic [15:0] a,
                                       input logic m, input logic e);
      if (kind == 0) return !e ? "R5" : ((m && a[14:8] == 7'd0) ? "R6" : "R2");
      if (a[15]) return (kind == 1) ? "R10" : "R11";
      if (a[15:8] == 8'h7E) return "R7";
      if (a[15:8] == 8'h7D) return "R8";
      return "R9";
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [5:0] sels_now();
      return {rom_sel, scratch_code_sel, scratch_ram_sel, gram_sel, xram_sel, creg_sel};
   endfunction

   task automatic drive(input logic f, input logic r, input logic w,
                        input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      fetch_stb = f; rd_stb = r; wr_stb = w; bus_addr = a; wdata = d;
      #1;
   endtask

   task automatic idle();
      drive(1'b0, 1'b0, 1'b0, 16'h0000, 8'h00);
   endtask

   task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
      drive(1'b0, 1'b0, 1'b1, a, d);
      idle();
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] lows [5];
      logic [5:0]  es;
      lows[0] = 16'h00; lows[1] = 16'h03; lows[2] = 16'hF3; lows[3] = 16'hF4; lows[4] = 16'hFF;

      ext_access = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset state
      drive(1'b1, 1'b0, 1'b0, 16'h1234, 8'h00);
      check("R1 fetch sel", 32'(sels_now()), 32'b100000);
      check("R1 rom_addr", 32'(rom_addr), 32'h01234);
      drive(1'b0, 1'b1, 1'b0, 16'h7FF3, 8'h00);
      check("R1 bank read", 32'(creg_rdata), 32'h00);
      drive(1'b0, 1'b1, 1'b0, 16'h7FF4, 8'h00);
      check("R1 cfg read", 32'(creg_rdata), 32'h00);
      idle();
      check("R13 idle", 32'(sels_now()), 32'h0);

      for (int b = 0; b < 8; b++) begin
         reg_write(16'h7FF3, 8'hA8 | 8'(b));
         drive(1'b0, 1'b1, 1'b0, 16'h7FF3, 8'h00);
         check("R3 bank readback", 32'(creg_rdata), 32'(b));
         for (int m = 0; m < 2; m++) begin
            reg_write(16'h7FF4, (m != 0) ? 8'hFF : 8'hF7);
            drive(1'b0, 1'b1, 1'b0, 16'h7FF4, 8'h00);
            check("R4 cfg readback", 32'(creg_rdata), (m != 0) ? 32'h08 : 32'h00);
            for (int e = 0; e < 2; e++) begin
               ext_access = e[0];
               for (int k = 0; k < 3; k++) begin
                  for (int hi = 0; hi < 256; hi++) begin
                     for (int li = 0; li < 5; li++) begin
                        logic [15:0] a;
                        a = {8'(hi), lows[li][7:0]};
                        if (k == 2 && (a == 16'h7FF3 || a == 16'h7FF4)) continue;
                        drive(k == 0, k == 1, k == 2, a, 8'h5A);
                        es = model_sel(k, a, m[0], e[0]);
                        check(model_req(k, a, m[0], e[0]), 32'(sels_now()), 32'(es));
                        if (es[5])
                           check(model_req(k, a, m[0], e[0]), 32'(rom_addr),
                                 32'({3'(b), a[14:0]}));
                     end
                  end
               end
            end
         end
      end
      idle();
      // R11: alias writes left both registers untouched (last values bank 7, mmc 1)
      drive(1'b0, 1'b1, 1'b0, 16'h7FF3, 8'h00);
      check("R11 bank after alias writes", 32'(creg_rdata), 32'h07);
      drive(1'b0, 1'b1, 1'b0, 16'h7FF4, 8'h00);
      check("R11 cfg after alias writes", 32'(creg_rdata), 32'h08);

      // R12 fetch and write in the same cycle: fetch served, write dropped
      ext_access = 1'b0;
      drive(1'b1, 1'b0, 1'b1, 16'h7FF3, 8'h02);
      check("R12 fetch wins sel", 32'(sels_now()), 32'b100000);
      check("R12 fetch wins addr", 32'(rom_addr), 32'({3'd7, 15'h7FF3}));
      idle();
      drive(1'b0, 1'b1, 1'b0, 16'h7FF3, 8'h00);
      check("R12 bank kept", 32'(creg_rdata), 32'h07);
      // R12 read and write together: write served
      drive(1'b0, 1'b1, 1'b1, 16'h7FF3, 8'h03);
      check("R12 write wins sel", 32'(sels_now()), 32'b000001);
      check("R12 write wins rdata", 32'(creg_rdata), 32'h00);
      drive(1'b1, 1'b0, 1'b0, 16'h0040, 8'h00);
      check("R3 next-cycle bank", 32'(rom_addr), 32'({3'd3, 15'h0040}));

      // R1 reset again restores defaults
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      ext_access = 1'b1;
      drive(1'b1, 1'b0, 1'b0, 16'h0010, 8'h00);
      check("R1 re-reset fetch", 32'({sels_now(), rom_addr}), 32'({6'b100000, 18'h00010}));
      idle();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule